// File: doc/BRIEF.md
# Per-Core Line Location Predictor

This block guesses where a requested memory line currently lives. There are four possible places: the fast stacked memory, or one of three slots in slow off-chip memory. The guess lets the memory controller start a speculative access to the guessed place. That access runs at the same time as the lookup of the authoritative location table, which is slower. Once the table answers, the controller sends back a resolution. The resolution gives the true location and the location that was predicted. The predictor then learns from it and reports whether the guess was wrong.

Each core has its own table. Each table entry holds the location last seen for its index, and that value is the next prediction for the index. The index is a hash of the instruction address that made the request. The predictor also counts resolved predictions and correct ones, so that accuracy can be computed outside the block.

Top module: `line_loc_pred`

## Requirements
- R1: After reset, every entry of every core predicts location 0 (fast memory). Both counters read 0, and `pred_valid_o` and `mispredict_o` are low.
- R2: A request in cycle n gives `pred_valid_o` high in cycle n+1, with `pred_loc_o` equal to the entry addressed by the request. The location encoding is 0 for fast memory and 1, 2 and 3 for slow locations 1 to 3. `pred_valid_o` is low in every cycle that follows a cycle with no request.
- R3: The entry index is `pc[9:2] ^ pc[31:24]`. Two addresses with the same index share one entry.
- R4: A resolution overwrites the addressed entry with `upd_loc_i`. Later requests to that index return the new value.
- R5: Each core has its own table. A resolution for one core leaves every other core's predictions unchanged.
- R6: A request and a resolution may arrive in the same cycle. If they address the same entry of the same core, the prediction returns the value held before the update.
- R7: `mispredict_o` is high for exactly one cycle, in the cycle after a resolution whose `upd_loc_i` differs from `upd_pred_i`. It is low in every other cycle.
- R8: `pred_total_o` increases by 1 on each resolution. `pred_correct_o` increases by 1 on each resolution where `upd_loc_i` equals `upd_pred_i`. Both take the new value one cycle after the resolution and wrap at 2^CNT_W.
- R9: Address bits [1:0] have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Prediction request strobe |
| req_core_i | input | CORE_W | Requesting core |
| req_pc_i | input | ADDR_W | Instruction address of the request |
| upd_valid_i | input | 1 | Resolution strobe |
| upd_core_i | input | CORE_W | Core of the resolved access |
| upd_pc_i | input | ADDR_W | Instruction address of the resolved access |
| upd_loc_i | input | 2 | True location |
| upd_pred_i | input | 2 | Location that was predicted for this access |
| pred_valid_o | output | 1 | Prediction valid, one cycle after the request |
| pred_loc_o | output | 2 | Predicted location |
| mispredict_o | output | 1 | One-cycle pulse for a wrong prediction |
| pred_total_o | output | CNT_W | Number of resolved predictions |
| pred_correct_o | output | CNT_W | Number of correct predictions |

## Verification
The bench builds the block with its default parameters: four cores, 256 entries per core, 32-bit addresses and 16-bit counters. With four cores, several tables can be trained on the same address, so cross-core isolation can be tested. The 32-bit address puts the upper hash byte at bits 31:24. That lets the bench build two addresses that alias to the same entry and test that they share it. The bench also sends requests and resolutions to the same entry in the same cycle, and runs a random mix of requests and resolutions against a behavioural model.

// File: rtl/llp_pkg.sv
package llp_pkg;
  localparam int unsigned LOC_W = 2;

  typedef enum logic [LOC_W-1:0] {
    LOC_FAST  = 2'd0,
    LOC_SLOW1 = 2'd1,
    LOC_SLOW2 = 2'd2,
    LOC_SLOW3 = 2'd3
  } loc_e;
endpackage

// File: rtl/llp_hash.sv
module llp_hash #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o
);
  // drop the 2-bit alignment, fold in the top byte
  assign idx_o = pc_i[IDX_W+1:2] ^ pc_i[ADDR_W-1 -: IDX_W];

  logic unused_bits;
  assign unused_bits = ^pc_i;
endmodule

// File: rtl/llp_table.sv
module llp_table
  import llp_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  loc_e             wr_loc_i,
  output loc_e             rd_loc_o
);
  loc_e mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= LOC_FAST;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_loc_i;
    end
  end

  // read samples the pre-update value on a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_loc_o <= LOC_FAST;
    else if (rd_en_i) rd_loc_o <= mem_q[rd_idx_i];
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_loc_o));

  // R6
  rd_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i && rd_idx_i == wr_idx_i) |=> rd_loc_o == $past(mem_q[rd_idx_i]));
endmodule

// File: rtl/llp_stats.sv
module llp_stats
  import llp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_valid_i,
  input  loc_e             upd_loc_i,
  input  loc_e             upd_pred_i,
  output logic             mispredict_o,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] correct_o
);
  logic hit;
  assign hit = (upd_loc_i == upd_pred_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mispredict_o <= 1'b0;
      total_o      <= '0;
      correct_o    <= '0;
    end else begin
      mispredict_o <= upd_valid_i && !hit;
      if (upd_valid_i) begin
        total_o <= total_o + 1'b1;
        if (hit) correct_o <= correct_o + 1'b1;
      end
    end
  end

  // R7
  no_false_misp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_loc_i == upd_pred_i) |=> !mispredict_o);

  // R8
  correct_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_loc_i == upd_pred_i) |=> correct_o == $past(correct_o) + 1'b1);

  // R8
  total_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(total_o) && $stable(correct_o));
endmodule

// File: rtl/line_loc_pred.sv
module line_loc_pred
  import llp_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ENTRIES   = 256,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [ADDR_W-1:0] req_pc_i,
  input  logic              upd_valid_i,
  input  logic [CORE_W-1:0] upd_core_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [1:0]        upd_loc_i,
  input  logic [1:0]        upd_pred_i,
  output logic              pred_valid_o,
  output logic [1:0]        pred_loc_o,
  output logic              mispredict_o,
  output logic [CNT_W-1:0]  pred_total_o,
  output logic [CNT_W-1:0]  pred_correct_o
);
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [CORE_W-1:0] core_q;
  loc_e              rd_loc [NUM_CORES];

  llp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd_hash (.pc_i(req_pc_i), .idx_o(rd_idx));
  llp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr_hash (.pc_i(upd_pc_i), .idx_o(wr_idx));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    llp_table #(.ENTRIES(ENTRIES)) u_tbl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_en_i  (req_valid_i && req_core_i == CORE_W'(g)),
      .rd_idx_i (rd_idx),
      .wr_en_i  (upd_valid_i && upd_core_i == CORE_W'(g)),
      .wr_idx_i (wr_idx),
      .wr_loc_i (loc_e'(upd_loc_i)),
      .rd_loc_o (rd_loc[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      core_q       <= '0;
    end else begin
      pred_valid_o <= req_valid_i;
      if (req_valid_i) core_q <= req_core_i;
    end
  end

  assign pred_loc_o = rd_loc[core_q];

  llp_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_valid_i  (upd_valid_i),
    .upd_loc_i    (loc_e'(upd_loc_i)),
    .upd_pred_i   (loc_e'(upd_pred_i)),
    .mispredict_o (mispredict_o),
    .total_o      (pred_total_o),
    .correct_o    (pred_correct_o)
  );

  // R2
  pred_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> pred_valid_o);

  // R2
  pred_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !pred_valid_o);

  // R7
  misp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> !mispredict_o);
endmodule

// File: tb/line_loc_pred_test.sv
module line_loc_pred_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NE = 256;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_core = '0;
  logic [31:0] req_pc = '0;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_core = '0;
  logic [31:0] upd_pc = '0;
  logic [1:0]  upd_loc = '0;
  logic [1:0]  upd_pred = '0;
  logic        pred_valid, mispredict;
  logic [1:0]  pred_loc;
  logic [CW-1:0] pred_total, pred_correct;

  line_loc_pred uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_core_i(req_core), .req_pc_i(req_pc),
    .upd_valid_i(upd_valid), .upd_core_i(upd_core), .upd_pc_i(upd_pc),
    .upd_loc_i(upd_loc), .upd_pred_i(upd_pred),
    .pred_valid_o(pred_valid), .pred_loc_o(pred_loc), .mispredict_o(mispredict),
    .pred_total_o(pred_total), .pred_correct_o(pred_correct)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int model [NC][NE];
  int exp_total = 0, exp_correct = 0;

  function automatic int hidx(logic [31:0] pc);
    return ((int'(pc) >>> 2) & 255) ^ ((int'(pc >> 24)) & 255);
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // one clock: drive, step the model, compare at the next falling edge
  task automatic cycle(bit rv, int rc, logic [31:0] rpc,
                       bit uv, int uc, logic [31:0] upc, int uloc, int upr,
                       string tag);
    int exp_pred;
    bit exp_misp;
    req_valid = rv; req_core = 2'(rc); req_pc = rpc;
    upd_valid = uv; upd_core = 2'(uc); upd_pc = upc;
    upd_loc = 2'(uloc); upd_pred = 2'(upr);
    exp_pred = rv ? model[rc][hidx(rpc)] : 0;
    exp_misp = uv && (uloc != upr);
    if (uv) begin
      model[uc][hidx(upc)] = uloc;
      exp_total = (exp_total + 1) % (1 << CW);
      if (uloc == upr) exp_correct = (exp_correct + 1) % (1 << CW);
    end
    @(negedge clk);
    check("R2 pred_valid", int'(pred_valid), int'(rv));
    if (rv) check(tag, int'(pred_loc), exp_pred);
    check("R7 mispredict", int'(mispredict), int'(exp_misp));
    check("R8 total", int'(pred_total), exp_total);
    check("R8 correct", int'(pred_correct), exp_correct);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb;
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) model[c][e] = 0;
    repeat (3) @(negedge clk);
    check("R1 pred_valid", int'(pred_valid), 0);
    check("R1 mispredict", int'(mispredict), 0);
    check("R1 total", int'(pred_total), 0);
    check("R1 correct", int'(pred_correct), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: untrained entries predict fast memory
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 4; k++)
        cycle(1, c, 32'h1000_0000 * k + 32'h40 * (c + 1), 0, 0, 0, 0, 0, "R1 reset entry");

    // R4: train then read back
    pa = 32'h0000_0040;
    cycle(0, 0, 0, 1, 0, pa, 2, 0, "R4 train");
    cycle(1, 0, pa, 0, 0, 0, 0, 0, "R4 readback");
    cycle(0, 0, 0, 1, 0, pa, 3, 2, "R4 retrain");
    cycle(1, 0, pa, 0, 0, 0, 0, 0, "R4 readback2");

    // R3: aliasing address shares the entry (idx 0x10)
    pb = 32'h0100_0044;
    cycle(1, 0, pb, 0, 0, 0, 0, 0, "R3 alias read");
    cycle(0, 0, 0, 1, 0, pb, 1, 3, "R3 alias write");
    cycle(1, 0, pa, 0, 0, 0, 0, 0, "R3 alias seen");

    // R9: low bits ignored
    cycle(1, 0, pa | 32'h3, 0, 0, 0, 0, 0, "R9 low bits");
    cycle(0, 0, 0, 1, 0, pa | 32'h2, 2, 1, "R9 low bits write");
    cycle(1, 0, pa, 0, 0, 0, 0, 0, "R9 low bits seen");

    // R5: other cores untouched
    cycle(0, 0, 0, 1, 1, pa, 3, 0, "R5 write core1");
    cycle(1, 0, pa, 0, 0, 0, 0, 0, "R5 core0 unchanged");
    cycle(1, 1, pa, 0, 0, 0, 0, 0, "R5 core1");
    cycle(1, 2, pa, 0, 0, 0, 0, 0, "R5 core2 unchanged");
    cycle(1, 3, pa, 0, 0, 0, 0, 0, "R5 core3 unchanged");

    // R6: same-cycle read and write of one entry
    cycle(1, 2, pa, 1, 2, pa, 1, 0, "R6 old value");
    cycle(1, 2, pa, 0, 0, 0, 0, 0, "R6 new value");
    cycle(1, 2, pa, 1, 2, pb, 3, 1, "R6 alias same cycle");
    cycle(1, 2, pa, 1, 3, pa, 2, 2, "R6 other core write");
    cycle(1, 2, pa, 0, 0, 0, 0, 0, "R6 after");

    // R7/R8: back-to-back correct and wrong resolutions
    cycle(0, 0, 0, 1, 3, 32'h80, 0, 0, "R8 hit");
    cycle(0, 0, 0, 1, 3, 32'h80, 1, 0, "R7 miss");
    cycle(0, 0, 0, 1, 3, 32'h80, 1, 1, "R8 hit2");
    idle();
    idle();

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r1, r2;
      r1 = {$urandom_range(3, 0) == 0 ? 8'h01 : 8'h00, 16'h0, 6'($urandom), 2'($urandom)};
      r2 = {$urandom_range(3, 0) == 0 ? 8'h01 : 8'h00, 16'h0, 6'($urandom), 2'($urandom)};
      cycle($urandom_range(1, 0) == 1, $urandom_range(NC - 1, 0), r1,
            $urandom_range(1, 0) == 1, $urandom_range(NC - 1, 0), r2,
            $urandom_range(3, 0), $urandom_range(3, 0), "R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule